// File: doc/BRIEF.md
# Multi-Thread Interrupt Aggregator

This block gathers the interrupt-pending lines of a bank of command-queue threads into one global status word and a single interrupt request for the CPU. Each thread's pending line is captured in a register stage and stored inverted: a status bit that reads 0 marks a thread waiting for service, and a status field of all ones means the whole bank is idle. The CPU interrupt is raised whenever any thread bit in that field is 0.

The block also owns the decode of the queue's register space. Addresses below the thread-window base belong to the global space, which holds the read-only status word and a read/write slot-cycle configuration register that scheduling logic elsewhere consumes. At and above the base, the address space is cut into equal power-of-two windows, one per thread. The block raises a one-hot thread select together with the offset inside that window, so that each thread's own register file can answer the access.

Top module: `thr_irq_aggr`

## Requirements
- R1: After reset the status read at offset 0x10 returns 0x0000FFFF, the interrupt output is low and the slot-cycle register at offset 0x30 reads 0.
- R2: Status bit i reads 0 one clock edge after pend_i[i] is high and 1 one edge after it is low; a change on pend_i is not visible before that edge.
- R3: Bits 31:16 of the status read are always 0.
- R4: irq_o is high exactly when at least one of the 16 status bits is 0.
- R5: A write to offset 0x10 leaves the status read unchanged.
- R6: A write to offset 0x30 stores all 32 data bits, which are then visible both on a read of 0x30 and on slot_cycles_o.
- R7: An address in [0x100 + 0x80*i, 0x100 + 0x80*i + 0x7F] raises only thr_sel_o[i] (bit i of the select) and drives win_off_o with the address minus the window start.
- R8: Addresses below 0x100 raise glob_sel_o and no thread select; addresses at or above the end of the last window (0x900) raise no select at all.
- R9: With acc_valid low, no select is raised and acc_rdata is 0.
- R10: Writes to a thread window or to an unused global offset do not change the slot-cycle register, and unused global offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pend_i | input | 16 | Per-thread interrupt-pending lines, active high |
| acc_valid | input | 1 | Register access strobe |
| acc_write | input | 1 | 1 for write, 0 for read |
| acc_addr | input | 12 | Byte address of the access |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data for global registers, 0 otherwise |
| irq_o | output | 1 | Aggregated CPU interrupt, active high |
| glob_sel_o | output | 1 | Access targets the global space |
| thr_sel_o | output | 16 | One-hot thread window select |
| win_off_o | output | 7 | Byte offset inside the selected thread window |
| slot_cycles_o | output | 32 | Current slot-cycle configuration |

## Verification
The bench targets the inverted status encoding: a design that stored the pending lines uncomplemented would read 0 at reset and raise the interrupt with no thread pending, and one that skipped the register stage would show a new pending bit before the clock edge. Window edges are probed at the first and last byte of thread 0, a middle thread and thread 15, plus the first address past the bank, where an off-by-one index or a missing upper bound would select a wrong or phantom thread. Writes aimed at the status offset, a thread window and an unused global offset check that only the slot register takes data, which catches a decode that lets a write through to the wrong register.

// File: rtl/tirq_pkg.sv
package tirq_pkg;
   localparam int unsigned DW = 32;

   typedef enum logic [1:0] {
      GREG_NONE = 2'd0,
      GREG_STAT = 2'd1,
      GREG_SLOT = 2'd2
   } greg_e;
endpackage

// File: rtl/tirq_pend_stage.sv
module tirq_pend_stage #(
   parameter int unsigned NT = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NT-1:0] pend_i,
   output logic [NT-1:0] status_n_o
);
   initial begin
      assert (NT >= 1 && NT <= 32) else $error("NT out of range");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status_n_o <= '1;
      else        status_n_o <= ~pend_i;
   end

   logic past_ok;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   assert_status_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> ((status_n_o & $past(pend_i)) == '0));
endmodule

// File: rtl/tirq_win_decode.sv
module tirq_win_decode
   import tirq_pkg::*;
#(
   parameter int unsigned AW         = 12,
   parameter int unsigned NT         = 16,
   parameter int unsigned WIN_BASE   = 256,
   parameter int unsigned WIN_STRIDE = 128,
   parameter int unsigned STAT_OFS   = 16,
   parameter int unsigned SLOT_OFS   = 48,
   localparam int unsigned SH        = $clog2(WIN_STRIDE),
   localparam int unsigned IW        = AW - SH
) (
   input  logic          valid_i,
   input  logic [AW-1:0] addr_i,
   output logic          glob_sel_o,
   output greg_e         greg_o,
   output logic [NT-1:0] thr_sel_o,
   output logic [SH-1:0] win_off_o
);
   initial begin
      assert (WIN_STRIDE >= 4 && (1 << SH) == WIN_STRIDE) else $error("stride must be a power of two");
      assert (WIN_BASE + WIN_STRIDE * NT <= (1 << AW)) else $error("windows exceed address space");
      assert (STAT_OFS < WIN_BASE && SLOT_OFS < WIN_BASE && STAT_OFS != SLOT_OFS) else $error("bad global offsets");
   end

   logic [AW-1:0] off;
   logic [IW-1:0] idx;
   logic          in_win;

   assign off    = addr_i - AW'(WIN_BASE);
   assign idx    = off[AW-1:SH];
   assign in_win = valid_i && (addr_i >= AW'(WIN_BASE));

   assign glob_sel_o = valid_i && (addr_i < AW'(WIN_BASE));
   assign win_off_o  = in_win ? off[SH-1:0] : '0;

   for (genvar i = 0; i < NT; i++) begin : g_sel
      assign thr_sel_o[i] = in_win && (idx == IW'(i));
   end

   always_comb begin
      greg_o = GREG_NONE;
      if (glob_sel_o) begin
         if (addr_i == AW'(STAT_OFS))      greg_o = GREG_STAT;
         else if (addr_i == AW'(SLOT_OFS)) greg_o = GREG_SLOT;
      end
   end

   always_comb begin
      assert_onehot_sel_R7: assert ($onehot0({glob_sel_o, thr_sel_o}));
      assert_idle_nosel_R9: assert (valid_i || (!glob_sel_o && thr_sel_o == '0));
   end
endmodule

// File: rtl/tirq_cfg_regs.sv
module tirq_cfg_regs
   import tirq_pkg::*;
#(
   parameter int unsigned NT       = 16,
   parameter logic [DW-1:0] SLOT_RST = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_i,
   input  greg_e         greg_i,
   input  logic [DW-1:0] wdata_i,
   input  logic [NT-1:0] status_n_i,
   output logic [DW-1:0] rdata_o,
   output logic [DW-1:0] slot_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           slot_o <= SLOT_RST;
      else if (wr_i && greg_i == GREG_SLOT) slot_o <= wdata_i;
   end

   always_comb begin
      unique case (greg_i)
         GREG_STAT: rdata_o = DW'(status_n_i);
         GREG_SLOT: rdata_o = slot_o;
         default:   rdata_o = '0;
      endcase
   end

   assert_slot_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && greg_i == GREG_SLOT) |=> (slot_o == $past(wdata_i)));
   assert_slot_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_i && greg_i == GREG_SLOT) |=> $stable(slot_o));
endmodule

// File: rtl/thr_irq_aggr.sv
module thr_irq_aggr
   import tirq_pkg::*;
#(
   parameter int unsigned NT         = 16,
   parameter int unsigned AW         = 12,
   parameter int unsigned WIN_BASE   = 256,
   parameter int unsigned WIN_STRIDE = 128,
   parameter int unsigned STAT_OFS   = 16,
   parameter int unsigned SLOT_OFS   = 48,
   parameter logic [31:0] SLOT_RST   = 32'h0,
   localparam int unsigned SH        = $clog2(WIN_STRIDE)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NT-1:0] pend_i,
   input  logic          acc_valid,
   input  logic          acc_write,
   input  logic [AW-1:0] acc_addr,
   input  logic [31:0]   acc_wdata,
   output logic [31:0]   acc_rdata,
   output logic          irq_o,
   output logic          glob_sel_o,
   output logic [NT-1:0] thr_sel_o,
   output logic [SH-1:0] win_off_o,
   output logic [31:0]   slot_cycles_o
);
   logic [NT-1:0] status_n;
   greg_e         greg;

   tirq_pend_stage #(.NT(NT)) u_pend (
      .clk        (clk),
      .rst_n      (rst_n),
      .pend_i     (pend_i),
      .status_n_o (status_n)
   );

   tirq_win_decode #(
      .AW(AW), .NT(NT), .WIN_BASE(WIN_BASE), .WIN_STRIDE(WIN_STRIDE),
      .STAT_OFS(STAT_OFS), .SLOT_OFS(SLOT_OFS)
   ) u_dec (
      .valid_i    (acc_valid),
      .addr_i     (acc_addr),
      .glob_sel_o (glob_sel_o),
      .greg_o     (greg),
      .thr_sel_o  (thr_sel_o),
      .win_off_o  (win_off_o)
   );

   tirq_cfg_regs #(.NT(NT), .SLOT_RST(SLOT_RST)) u_cfg (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_i       (acc_write),
      .greg_i     (greg),
      .wdata_i    (acc_wdata),
      .status_n_i (status_n),
      .rdata_o    (acc_rdata),
      .slot_o     (slot_cycles_o)
   );

   assign irq_o = ~&status_n;

   logic past_ok;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   assert_irq_on_pend_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(|pend_i)) |-> irq_o);
   assert_irq_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && !$past(|pend_i)) |-> !irq_o);

   always_comb begin
      assert_stat_upper_R3: assert (!(acc_valid && acc_addr == AW'(STAT_OFS)) || acc_rdata[31:16] == 16'h0);
   end
endmodule

// File: tb/thr_irq_aggr_test.sv
module thr_irq_aggr_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] pend_i = '0;
   logic        acc_valid = 1'b0;
   logic        acc_write = 1'b0;
   logic [11:0] acc_addr = '0;
   logic [31:0] acc_wdata = '0;
   logic [31:0] acc_rdata;
   logic        irq_o, glob_sel_o;
   logic [15:0] thr_sel_o;
   logic [6:0]  win_off_o;
   logic [31:0] slot_cycles_o;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   thr_irq_aggr uut (
      .clk(clk), .rst_n(rst_n), .pend_i(pend_i),
      .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
      .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .irq_o(irq_o),
      .glob_sel_o(glob_sel_o), .thr_sel_o(thr_sel_o), .win_off_o(win_off_o),
      .slot_cycles_o(slot_cycles_o)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      acc_valid = 1'b1; acc_write = 1'b0; acc_addr = a;
      #1 d = acc_rdata;
      @(negedge clk);
      acc_valid = 1'b0;
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      acc_valid = 1'b1; acc_write = 1'b1; acc_addr = a; acc_wdata = d;
      @(negedge clk);
      acc_valid = 1'b0; acc_write = 1'b0;
   endtask

   task automatic t_reset;
      logic [31:0] d;
      rd(12'h010, d);
      chk(d == 32'h0000FFFF, "R1 status", d, 32'h0000FFFF);
      chk(irq_o == 1'b0, "R1 irq", 32'(irq_o), 0);
      rd(12'h030, d);
      chk(d == 32'h0, "R1 slot", d, 0);
   endtask

   task automatic t_pend(input logic [15:0] p);
      logic [31:0] d;
      logic [15:0] exp_n;
      exp_n = ~p;
      @(negedge clk);
      pend_i = p;
      acc_valid = 1'b1; acc_write = 1'b0; acc_addr = 12'h010;
      #1;
      chk(acc_rdata[15:0] != exp_n || p == '0 || acc_rdata == 32'h0000FFFF, "R2 before edge", acc_rdata, 32'h0000FFFF);
      @(negedge clk);
      acc_valid = 1'b0;
      rd(12'h010, d);
      chk(d == {16'h0, exp_n}, "R2 status", d, {16'h0, exp_n});
      chk(d[31:16] == 16'h0, "R3 upper", d, {16'h0, exp_n});
      chk(irq_o == (p != 16'h0), "R4 irq", 32'(irq_o), 32'(p != 16'h0));
   endtask

   task automatic t_status_write;
      logic [31:0] d;
      wr(12'h010, 32'h12345678);
      rd(12'h010, d);
      chk(d == 32'h0000FFDE, "R5 status write ignored", d, 32'h0000FFDE);
   endtask

   task automatic t_slot;
      logic [31:0] d;
      wr(12'h030, 32'h00003200);
      rd(12'h030, d);
      chk(d == 32'h00003200, "R6 slot read", d, 32'h00003200);
      chk(slot_cycles_o == 32'h00003200, "R6 slot port", slot_cycles_o, 32'h00003200);
      wr(12'h030, 32'hA5A5C3C3);
      rd(12'h030, d);
      chk(d == 32'hA5A5C3C3, "R6 slot full width", d, 32'hA5A5C3C3);
      wr(12'h3B0, 32'h0);
      wr(12'h034, 32'h0);
      wr(12'h0F0, 32'h0);
      chk(slot_cycles_o == 32'hA5A5C3C3, "R10 slot kept", slot_cycles_o, 32'hA5A5C3C3);
      rd(12'h034, d);
      chk(d == 32'h0, "R10 unused reads 0", d, 0);
   endtask

   task automatic t_win(input logic [11:0] a, input int thr, input logic [6:0] off);
      logic [15:0] es;
      es = (thr >= 0) ? (16'h1 << thr) : 16'h0;
      @(negedge clk);
      acc_valid = 1'b1; acc_write = 1'b0; acc_addr = a;
      #1;
      chk(thr_sel_o == es, "R7 thread select", 32'(thr_sel_o), 32'(es));
      if (thr >= 0) chk(win_off_o == off, "R7 window offset", 32'(win_off_o), 32'(off));
      chk(glob_sel_o == (a < 12'h100), "R8 global select", 32'(glob_sel_o), 32'(a < 12'h100));
      @(negedge clk);
      acc_valid = 1'b0;
   endtask

   task automatic t_idle;
      @(negedge clk);
      acc_valid = 1'b0; acc_addr = 12'h010;
      #1;
      chk(!glob_sel_o && thr_sel_o == '0, "R9 no select", {15'h0, glob_sel_o, thr_sel_o}, 0);
      chk(acc_rdata == 32'h0, "R9 rdata", acc_rdata, 0);
   endtask

   task automatic summary;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_pend(16'h0021);
      t_status_write();
      t_pend(16'h8001);
      t_pend(16'hFFFF);
      t_pend(16'h0000);
      t_pend(16'h0021);
      t_slot();
      t_win(12'h100, 0, 7'h00);
      t_win(12'h17F, 0, 7'h7F);
      t_win(12'h3A4, 5, 7'h24);
      t_win(12'h880, 15, 7'h00);
      t_win(12'h8FF, 15, 7'h7F);
      t_win(12'h900, -1, 7'h00);
      t_win(12'h0FC, -1, 7'h00);
      t_idle();
      done = 1'b1;
      summary();
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 0, 1);
         summary();
      end
   end
endmodule